// File: doc/BRIEF.md
# Asymmetric Dual-Issue Pairing Unit

This block sits at the first decode stage of an in-order core that has two integer pipes of unequal capability. Each cycle it looks at the two oldest entries of the decoded-instruction queue and decides whether they can leave together or whether only the older one may go. The older instruction always goes to the full-capability primary pipe. The younger one is sent to the restricted secondary pipe only when its operation class is allowed there and it has no register conflict with its partner. The block reports how many queue entries were consumed so that the queue can pop them.

Every issued instruction receives a sequence tag. The block carries those tags through lockstep stages (second decode, execute, write-back) to a pair of retirement ports. A pair retires in the same cycle, with the primary-pipe instruction on the first port and the secondary-pipe instruction on the second. A stall on either pipe freezes the whole lockstep structure, so the two pipes never drift apart.

Top module: `dual_issue_pairer`

## Requirements
- R1: No more than two instructions issue per cycle. `deq_count` is 0, 1 or 2 and equals the number of instructions issued in that cycle.
- R2: When both queue heads can pair, the older one (slot 0) appears on the primary issue slot and the younger one (slot 1) on the secondary slot. Both carry their class codes and `deq_count` is 2.
- R3: When the heads cannot pair and slot 0 is valid, only slot 0 issues, to the primary pipe. The secondary slot holds a bubble (valid low) and `deq_count` is 1.
- R4: Class codes on 2 bits: 00 plain ALU may use either pipe; 01 may use only the primary pipe; 10 branch may pair only as the younger (secondary) instruction; 11 never pairs, in either position. Pairing needs an older class of 00 or 01 and a younger class of 00 or 10.
- R5: Pairing is refused when the older instruction writes a register (write enable high) and the younger one reads it through either source index, or also writes the same destination index.
- R6: While `u_stall` or `v_stall` is high, `deq_count` is 0, no new instruction issues, and both issue slots keep their previous contents.
- R7: With slot 0 valid and slot 1 invalid, slot 0 issues alone. With slot 0 invalid, nothing issues, whatever slot 1 holds.
- R8: Tags start at 0 after reset and increase by one per issued instruction, modulo 2^TAG_W. In a pair, the primary tag is t and the secondary tag is t+1.
- R9: An issued instruction reaches the retirement ports after three further non-stalled cycles. A pair retires in the same cycle, primary tag on `ret0`, secondary tag on `ret1`. The retirement ports are empty in any cycle that follows a stalled edge.
- R10: After reset all issue and retirement valids are low and `deq_count` is 0 for an empty queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot0_valid | input | 1 | Oldest queue entry present |
| slot0_class | input | 2 | Oldest entry operation class |
| slot0_dst | input | REG_W | Oldest entry destination index |
| slot0_dst_we | input | 1 | Oldest entry writes its destination |
| slot1_valid | input | 1 | Second-oldest entry present |
| slot1_class | input | 2 | Second entry operation class |
| slot1_src_a | input | REG_W | Second entry first source index |
| slot1_src_b | input | REG_W | Second entry second source index |
| slot1_dst | input | REG_W | Second entry destination index |
| slot1_dst_we | input | 1 | Second entry writes its destination |
| u_stall | input | 1 | Primary pipe stall |
| v_stall | input | 1 | Secondary pipe stall |
| deq_count | output | 2 | Entries consumed this cycle |
| u_valid | output | 1 | Primary issue slot occupied |
| u_class | output | 2 | Primary slot class |
| u_tag | output | TAG_W | Primary slot sequence tag |
| v_valid | output | 1 | Secondary issue slot occupied |
| v_class | output | 2 | Secondary slot class |
| v_tag | output | TAG_W | Secondary slot sequence tag |
| ret0_valid | output | 1 | First retirement port valid |
| ret0_tag | output | TAG_W | First retirement tag |
| ret1_valid | output | 1 | Second retirement port valid |
| ret1_tag | output | TAG_W | Second retirement tag |

## Verification
The bench uses a 2-bit register index and sweeps every combination of the two valid flags, both class codes, both write enables, the older destination, and the younger's two sources and destination. This covers every class pair, and for each one it covers the conflict-free case, each read hazard on either source, and the write-after-write hazard. Stalls on either pipe, and on both at once, are mixed in with the vectors. They show whether a frozen pipe still drops an entry, issues a duplicate, or lets a retirement port repeat a tag. Because the tag width is 4 bits, the tag counter wraps thousands of times during the run, so an off-by-one in pair tag numbering or retirement ordering appears at once.

// File: rtl/pair_pkg.sv
package pair_pkg;

   typedef enum logic [1:0] {
      CLS_ALU    = 2'b00,
      CLS_UONLY  = 2'b01,
      CLS_BRANCH = 2'b10,
      CLS_SOLO   = 2'b11
   } op_class_e;

   // Which classes are allowed in each position of a pair
   function automatic logic fits_primary(input logic [1:0] c);
      return (c == CLS_ALU) || (c == CLS_UONLY);
   endfunction

   function automatic logic fits_secondary(input logic [1:0] c);
      return (c == CLS_ALU) || (c == CLS_BRANCH);
   endfunction

endpackage

// File: rtl/pair_rules.sv
module pair_rules
   import pair_pkg::*;
#(
   parameter int REG_W     = 5,
   parameter bit WAW_CHECK = 1'b1
) (
   input  logic             old_valid,
   input  logic [1:0]       old_class,
   input  logic [REG_W-1:0] old_dst,
   input  logic             old_dst_we,
   input  logic             yng_valid,
   input  logic [1:0]       yng_class,
   input  logic [REG_W-1:0] yng_src_a,
   input  logic [REG_W-1:0] yng_src_b,
   input  logic [REG_W-1:0] yng_dst,
   input  logic             yng_dst_we,
   output logic             pair_ok,
   output logic             single_ok
);

   if (REG_W < 1) begin : g_bad_regw
      $error("pair_rules: REG_W must be at least 1");
   end

   logic raw_hit;
   logic waw_hit;
   logic class_ok;

   assign raw_hit = old_dst_we && ((yng_src_a == old_dst) || (yng_src_b == old_dst));

   if (WAW_CHECK) begin : g_waw_on
      assign waw_hit = old_dst_we && yng_dst_we && (yng_dst == old_dst);
   end else begin : g_waw_off
      logic unused_waw;
      assign unused_waw = ^{yng_dst, yng_dst_we};
      assign waw_hit    = 1'b0;
   end

   assign class_ok  = fits_primary(old_class) && fits_secondary(yng_class);
   assign single_ok = old_valid;
   assign pair_ok   = old_valid && yng_valid && class_ok && !raw_hit && !waw_hit;

endmodule

// File: rtl/tag_counter.sv
module tag_counter #(
   parameter int TAG_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       step,
   output logic [TAG_W-1:0] cur
);

   if (TAG_W < 2) begin : g_bad_tagw
      $error("tag_counter: TAG_W must be at least 2");
   end

   localparam int PAD_W = TAG_W - 2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur <= '0;
      else        cur <= cur + {{PAD_W{1'b0}}, step};
   end

   p_step_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      step != 2'd3);

endmodule

// File: rtl/lockstep_pipe.sv
module lockstep_pipe #(
   parameter int W      = 8,
   parameter int STAGES = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (STAGES < 1) begin : g_bad_stages
      $error("lockstep_pipe: STAGES must be at least 1");
   end

   logic [W-1:0] stg [STAGES];
   logic [W-1:0] prv [STAGES];

   assign prv[0] = din;

   for (genvar s = 1; s < STAGES; s++) begin : g_link
      assign prv[s] = stg[s-1];
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == STAGES - 1) begin : g_last
         // final stage emits a bubble whenever the pipes are frozen
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   stg[s] <= '0;
            else if (adv) stg[s] <= prv[s];
            else          stg[s] <= '0;
         end
      end else begin : g_mid
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   stg[s] <= '0;
            else if (adv) stg[s] <= prv[s];
         end
      end
   end

   assign dout = stg[STAGES-1];

endmodule

// File: rtl/dual_issue_pairer.sv
module dual_issue_pairer
   import pair_pkg::*;
#(
   parameter int REG_W       = 5,
   parameter int TAG_W       = 6,
   parameter int POST_STAGES = 3,
   parameter bit WAW_CHECK   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slot0_valid,
   input  logic [1:0]       slot0_class,
   input  logic [REG_W-1:0] slot0_dst,
   input  logic             slot0_dst_we,
   input  logic             slot1_valid,
   input  logic [1:0]       slot1_class,
   input  logic [REG_W-1:0] slot1_src_a,
   input  logic [REG_W-1:0] slot1_src_b,
   input  logic [REG_W-1:0] slot1_dst,
   input  logic             slot1_dst_we,
   input  logic             u_stall,
   input  logic             v_stall,
   output logic [1:0]       deq_count,
   output logic             u_valid,
   output logic [1:0]       u_class,
   output logic [TAG_W-1:0] u_tag,
   output logic             v_valid,
   output logic [1:0]       v_class,
   output logic [TAG_W-1:0] v_tag,
   output logic             ret0_valid,
   output logic [TAG_W-1:0] ret0_tag,
   output logic             ret1_valid,
   output logic [TAG_W-1:0] ret1_tag
);

   localparam int ENT_W = 2 + 2 * TAG_W;

   if (POST_STAGES < 1) begin : g_bad_post
      $error("dual_issue_pairer: POST_STAGES must be at least 1");
   end

   logic             pair_ok;
   logic             single_ok;
   logic             adv;
   logic             issue_u;
   logic             issue_v;
   logic [TAG_W-1:0] next_tag;
   logic [TAG_W-1:0] next_tag_p1;
   logic [ENT_W-1:0] ret_ent;

   pair_rules #(
      .REG_W     (REG_W),
      .WAW_CHECK (WAW_CHECK)
   ) i_rules (
      .old_valid  (slot0_valid),
      .old_class  (slot0_class),
      .old_dst    (slot0_dst),
      .old_dst_we (slot0_dst_we),
      .yng_valid  (slot1_valid),
      .yng_class  (slot1_class),
      .yng_src_a  (slot1_src_a),
      .yng_src_b  (slot1_src_b),
      .yng_dst    (slot1_dst),
      .yng_dst_we (slot1_dst_we),
      .pair_ok    (pair_ok),
      .single_ok  (single_ok)
   );

   assign adv       = !(u_stall || v_stall);
   assign issue_u   = adv && single_ok;
   assign issue_v   = adv && pair_ok;
   assign deq_count = issue_v ? 2'd2 : (issue_u ? 2'd1 : 2'd0);

   tag_counter #(.TAG_W(TAG_W)) i_tags (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (deq_count),
      .cur   (next_tag)
   );

   assign next_tag_p1 = next_tag + TAG_W'(1);

   // First decode stage: the issue slots themselves
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         u_valid <= 1'b0;
         u_class <= 2'b00;
         u_tag   <= '0;
         v_valid <= 1'b0;
         v_class <= 2'b00;
         v_tag   <= '0;
      end else if (adv) begin
         u_valid <= issue_u;
         u_class <= issue_u ? slot0_class : 2'b00;
         u_tag   <= issue_u ? next_tag : '0;
         v_valid <= issue_v;
         v_class <= issue_v ? slot1_class : 2'b00;
         v_tag   <= issue_v ? next_tag_p1 : '0;
      end
   end

   lockstep_pipe #(
      .W      (ENT_W),
      .STAGES (POST_STAGES)
   ) i_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .din   ({u_valid, u_tag, v_valid, v_tag}),
      .dout  (ret_ent)
   );

   assign {ret0_valid, ret0_tag, ret1_valid, ret1_tag} = ret_ent;

   // ---------------- assertions ----------------
   logic [TAG_W-1:0] u_tag_p1;
   logic [TAG_W-1:0] ret0_tag_p1;
   logic [TAG_W-1:0] last_ret;
   logic [TAG_W-1:0] last_ret_p1;
   logic             seen_ret;

   assign u_tag_p1    = u_tag + TAG_W'(1);
   assign ret0_tag_p1 = ret0_tag + TAG_W'(1);
   assign last_ret_p1 = last_ret + TAG_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_ret <= 1'b0;
         last_ret <= '0;
      end else if (ret0_valid) begin
         seen_ret <= 1'b1;
         last_ret <= ret1_valid ? ret1_tag : ret0_tag;
      end
   end

   p_v_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
      v_valid |-> (v_class == CLS_ALU || v_class == CLS_BRANCH));

   p_v_needs_u_r3: assert property (@(posedge clk) disable iff (!rst_n)
      v_valid |-> u_valid);

   p_pair_tags_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (u_valid && v_valid) |-> (v_tag == u_tag_p1));

   p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (u_stall || v_stall) |=> ($stable(u_valid) && $stable(u_tag) &&
                                $stable(v_valid) && $stable(v_tag)));

   p_ret_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ret1_valid |-> (ret0_valid && ret1_tag == ret0_tag_p1));

   p_ret_seq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_ret && ret0_valid) |-> (ret0_tag == last_ret_p1));

endmodule

// File: tb/test_dual_issue_pairer.sv
`timescale 1ns/1ps
module test_dual_issue_pairer;

   localparam int RW = 2;
   localparam int TW = 4;

   typedef struct packed {
      logic          uv;
      logic [1:0]    uc;
      logic [TW-1:0] ut;
      logic          vv;
      logic [1:0]    vc;
      logic [TW-1:0] vt;
   } ent_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic s0v, s1v, s0we, s1we, us, vs;
   logic [1:0] s0c, s1c;
   logic [RW-1:0] s0d, s1a, s1b, s1d;
   logic [1:0] deq;
   logic uv, vv, r0v, r1v;
   logic [1:0] uc, vc;
   logic [TW-1:0] ut, vt, r0t, r1t;

   int vectors = 0;
   int fails = 0;
   bit done = 0;

   ent_t m [4];
   logic [TW-1:0] ntag;

   always #2 clk = ~clk;

   dual_issue_pairer #(.REG_W(RW), .TAG_W(TW), .POST_STAGES(3), .WAW_CHECK(1'b1)) i_dual_issue_pairer (
      .clk(clk), .rst_n(rst_n),
      .slot0_valid(s0v), .slot0_class(s0c), .slot0_dst(s0d), .slot0_dst_we(s0we),
      .slot1_valid(s1v), .slot1_class(s1c), .slot1_src_a(s1a), .slot1_src_b(s1b),
      .slot1_dst(s1d), .slot1_dst_we(s1we),
      .u_stall(us), .v_stall(vs), .deq_count(deq),
      .u_valid(uv), .u_class(uc), .u_tag(ut),
      .v_valid(vv), .v_class(vc), .v_tag(vt),
      .ret0_valid(r0v), .ret0_tag(r0t), .ret1_valid(r1v), .ret1_tag(r1t)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         if (fails < 20) $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic check_outputs();
      chk(uv == m[0].uv, "R2/R3 primary valid", uv, m[0].uv);
      if (m[0].uv) begin
         chk(ut == m[0].ut, "R8 primary tag", ut, m[0].ut);
         chk(uc == m[0].uc, "R2 primary class", uc, m[0].uc);
      end
      chk(vv == m[0].vv, "R3/R4/R5 secondary valid", vv, m[0].vv);
      if (m[0].vv) begin
         chk(vt == m[0].vt, "R8 secondary tag", vt, m[0].vt);
         chk(vc == m[0].vc, "R2 secondary class", vc, m[0].vc);
      end
      chk(r0v == m[3].uv, "R9 retire0 valid", r0v, m[3].uv);
      chk(r1v == m[3].vv, "R9 retire1 valid", r1v, m[3].vv);
      if (m[3].uv) chk(r0t == m[3].ut, "R9 retire0 tag", r0t, m[3].ut);
      if (m[3].vv) chk(r1t == m[3].vt, "R9 retire1 tag", r1t, m[3].vt);
   endtask

   // Called just after a falling edge; returns after the next falling edge
   task automatic run_vec(input logic [15:0] vec, input logic su, input logic sv);
      logic can_pair, hazard, stall;
      ent_t nw;
      {s0v, s1v, s0c, s1c, s0we, s1we, s0d, s1a, s1b, s1d} = vec;
      us = su;
      vs = sv;
      stall = su | sv;
      #1;
      hazard   = s0we && ((s1a == s0d) || (s1b == s0d) || (s1we && s1d == s0d));
      can_pair = s0v && s1v && (s0c inside {2'b00, 2'b01}) && (s1c inside {2'b00, 2'b10}) && !hazard;
      nw = '0;
      if (!stall && s0v) begin
         nw.uv = 1'b1; nw.uc = s0c; nw.ut = ntag;
         if (can_pair) begin
            nw.vv = 1'b1; nw.vc = s1c; nw.vt = ntag + TW'(1);
         end
      end
      if (stall)
         chk(deq == 2'd0, "R6 stall dequeue", deq, 0);
      else if (!s0v)
         chk(deq == 2'd0, "R7 empty head", deq, 0);
      else
         chk(deq == (can_pair ? 2'd2 : 2'd1), "R1 dequeue count", deq, can_pair ? 2 : 1);
      @(posedge clk);
      if (stall) begin
         m[3] = '0;
      end else begin
         m[3] = m[2]; m[2] = m[1]; m[1] = m[0]; m[0] = nw;
         ntag = ntag + TW'(nw.uv) + TW'(nw.vv);
      end
      @(negedge clk);
      check_outputs();
   endtask

   initial begin
      {s0v, s1v, s0we, s1we, us, vs} = '0;
      {s0c, s1c, s0d, s1a, s1b, s1d} = '0;
      for (int k = 0; k < 4; k++) m[k] = '0;
      ntag = '0;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(!uv && !vv && !r0v && !r1v, "R10 reset valids", {uv, vv, r0v, r1v}, 0);
      chk(deq == 2'd0, "R10 reset dequeue", deq, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_outputs();
      for (int i = 0; i < 65536; i++) begin
         if (i % 5 == 0)
            run_vec(16'(i), (i % 3) != 1, (i % 3) != 0);
         run_vec(16'(i), 1'b0, 1'b0);
      end
      for (int k = 0; k < 5; k++) run_vec(16'h0000, 1'b0, 1'b0);
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         vectors++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule